// File: doc/BRIEF.md
# Fractional Phase-Accumulator Clock Generator Bank

This block holds four independent clock generators that run from a single reference clock. Each generator keeps a 32-bit phase accumulator. On every reference cycle the accumulator adds a programmed increment N. The accumulator's top bit is the generated square wave, so its average frequency is the reference frequency times N / 2^32. An increment of zero stops the generator, and its output then rests low. Increments are capped so that a generator never runs faster than half the reference.

A bank of output pins sits beside the generators. Each pin has a small configuration word: a drive-enable bit, a clock-mode bit and a 2-bit generator select. A pin whose drive-enable and clock-mode bits are both set carries the chosen generator's clock. Any other pin passes its ordinary output data through.

Both the increments and the pin words are loaded through plain write strobes: one strobe and index for increments, and one strobe and index for pin words. Each write lands on the next reference edge. There is no read-back path and no flow-controlled interface; every port is a plain control or data level.

Top module: `fcg_top`

## Requirements
- R1: After reset, every increment and accumulator is zero, every `gen_clk` bit is 0, every `pin_oe` bit is 0, and `pin_out` equals `pin_data`.
- R2: A write with `inc_we`=1 loads `inc_val` into the generator numbered `inc_idx` at that clock edge. The other three generators are unaffected.
- R3: When a generator's stored increment is 0, its accumulator is cleared on the next edge and its `gen_clk` bit stays 0 for as long as the increment remains 0.
- R4: A written value above 2^31-1 (bit 31 set) is stored as 2^31-1.
- R5: While a generator's increment N is nonzero, its accumulator grows by N (mod 2^32) on every edge, and `gen_clk[g]` is accumulator bit 31. For example, N=2^29 starting from zero gives 4 cycles low, then 4 cycles high.
- R6: A new nonzero increment is used from the edge after the write. The accumulator value is carried over rather than reset, and the edge on which the write lands still adds the old increment.
- R7: `pin_out[p]` equals the selected generator's clock when pin p's drive-enable and clock-mode bits are both 1; otherwise it equals `pin_data[p]`.
- R8: The 2-bit select value k (0..3) routes `gen_clk[k]` to a clock-mode pin.
- R9: A write with `pin_we`=1 loads pin `pin_idx`'s word at that edge, and `pin_oe[p]` equals its stored drive-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_we | input | 1 | Increment write strobe |
| inc_idx | input | 2 | Generator number for the increment write |
| inc_val | input | 32 | Increment value N |
| pin_we | input | 1 | Pin word write strobe |
| pin_idx | input | 3 | Pin number for the pin word write |
| pin_oe_set | input | 1 | Drive-enable bit of the written pin word |
| pin_clk_mode | input | 1 | Clock-mode bit of the written pin word |
| pin_gen_sel | input | 2 | Generator select of the written pin word |
| pin_data | input | 8 | Ordinary output data per pin |
| gen_clk | output | 4 | Generated clock of each generator |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench retunes a running generator and compares it against a cycle-accurate phase model. A design that cleared the accumulator on a write, or used the new increment one edge early, would shift the waveform's phase and miscompare. Writing 0 to a running generator checks that its output falls and stays low rather than freezing high. Writing 0xFFFFFFFF checks the cap: a design without it would count downward and show a high output on the first cycle. The pin tests walk all four select values and set drive-enable and clock-mode separately, which catches a mux that keys on only one of the two bits or decodes the select wrongly.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned GEN_COUNT = 4;
  localparam int unsigned GSEL_W    = $clog2(GEN_COUNT);

  // Per-pin configuration word
  typedef struct packed {
    logic              drive_en;
    logic              clk_mode;
    logic [GSEL_W-1:0] gen_sel;
  } pin_cfg_t;
endpackage

// File: rtl/fcg_accum.sv
module fcg_accum #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_we,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [ACC_W-1:0] inc_val,
  output logic             tick_out
);
  localparam logic [ACC_W-1:0] INC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_next;
  logic             wr_hit;

  assign wr_hit   = inc_we && (inc_idx == IDX_W'(MY_IDX));
  assign inc_next = inc_val[ACC_W-1] ? INC_MAX : inc_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q <= '0;
      acc_q <= '0;
    end else begin
      if (wr_hit) inc_q <= inc_next;
      if (inc_q == '0) acc_q <= '0;
      else             acc_q <= acc_q + inc_q;
    end
  end

  assign tick_out = acc_q[ACC_W-1];

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !inc_val[ACC_W-1]) |=> (inc_q == $past(inc_val)));

  assert_stop_holds_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0) |=> (acc_q == '0 && !tick_out));

  assert_inc_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q <= INC_MAX));

  assert_retune_keeps_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && inc_q != '0) |=> (acc_q == $past(acc_q) + $past(inc_q)));
endmodule

// File: rtl/fcg_pin_slice.sv
module fcg_pin_slice
  import fcg_pkg::*;
#(
  parameter int unsigned PIDX_W = 3,
  parameter int unsigned MY_PIN = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PIDX_W-1:0]    cfg_idx,
  input  pin_cfg_t             cfg_in,
  input  logic [GEN_COUNT-1:0] gen_clks,
  input  logic                 data_in,
  output logic                 pin_out,
  output logic                 oe_out
);
  pin_cfg_t cfg_q;
  logic     hit;

  assign hit = cfg_we && (cfg_idx == PIDX_W'(MY_PIN));

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (hit) cfg_q <= cfg_in;
  end

  assign pin_out = (cfg_q.drive_en && cfg_q.clk_mode) ? gen_clks[cfg_q.gen_sel] : data_in;
  assign oe_out  = cfg_q.drive_en;

  assert_pin_word_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (oe_out == $past(cfg_in.drive_en)));

  assert_data_when_not_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(cfg_in.drive_en && cfg_in.clk_mode)) |=> (pin_out == data_in));
endmodule

// File: rtl/fcg_top.sv
module fcg_top
  import fcg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ACC_W    = 32,
  localparam int unsigned PIDX_W  = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_we,
  input  logic [GSEL_W-1:0]    inc_idx,
  input  logic [ACC_W-1:0]     inc_val,
  input  logic                 pin_we,
  input  logic [PIDX_W-1:0]    pin_idx,
  input  logic                 pin_oe_set,
  input  logic                 pin_clk_mode,
  input  logic [GSEL_W-1:0]    pin_gen_sel,
  input  logic [NUM_PINS-1:0]  pin_data,
  output logic [GEN_COUNT-1:0] gen_clk,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe
);
  pin_cfg_t wr_cfg;

  assign wr_cfg = '{drive_en: pin_oe_set, clk_mode: pin_clk_mode, gen_sel: pin_gen_sel};

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    fcg_accum #(.ACC_W(ACC_W), .IDX_W(GSEL_W), .MY_IDX(g)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_we   (inc_we),
      .inc_idx  (inc_idx),
      .inc_val  (inc_val),
      .tick_out (gen_clk[g])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    fcg_pin_slice #(.PIDX_W(PIDX_W), .MY_PIN(p)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (pin_we),
      .cfg_idx  (pin_idx),
      .cfg_in   (wr_cfg),
      .gen_clks (gen_clk),
      .data_in  (pin_data[p]),
      .pin_out  (pin_out[p]),
      .oe_out   (pin_oe[p])
    );
  end
endmodule

// File: tb/fcg_top_bench.sv
module fcg_top_bench;
  import fcg_pkg::*;

  localparam int NP = 8;
  localparam time CLK_HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inc_we = 1'b0;
  logic [1:0]    inc_idx = '0;
  logic [31:0]   inc_val = '0;
  logic          pin_we = 1'b0;
  logic [2:0]    pin_idx = '0;
  logic          pin_oe_set = 1'b0;
  logic          pin_clk_mode = 1'b0;
  logic [1:0]    pin_gen_sel = '0;
  logic [NP-1:0] pin_data = 8'h3C;
  logic [3:0]    gen_clk;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_inc [4];
  logic [31:0] m_acc [4];
  pin_cfg_t    m_cfg [NP];

  always #(CLK_HALF) clk = ~clk;

  fcg_top u_fcg_top (
    .clk(clk), .rst_n(rst_n), .inc_we(inc_we), .inc_idx(inc_idx), .inc_val(inc_val),
    .pin_we(pin_we), .pin_idx(pin_idx), .pin_oe_set(pin_oe_set), .pin_clk_mode(pin_clk_mode),
    .pin_gen_sel(pin_gen_sel), .pin_data(pin_data), .gen_clk(gen_clk), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One reference cycle: model updates with the values driven before the edge
  task automatic cyc();
    @(posedge clk);
    for (int g = 0; g < 4; g++)
      m_acc[g] = (m_inc[g] == 0) ? 32'h0 : m_acc[g] + m_inc[g];
    if (inc_we) m_inc[inc_idx] = inc_val[31] ? 32'h7FFF_FFFF : inc_val;
    if (pin_we) m_cfg[pin_idx] = '{drive_en: pin_oe_set, clk_mode: pin_clk_mode, gen_sel: pin_gen_sel};
    @(negedge clk);
    inc_we = 1'b0;
    pin_we = 1'b0;
  endtask

  function automatic logic [3:0] exp_gen();
    logic [3:0] v;
    for (int g = 0; g < 4; g++) v[g] = m_acc[g][31];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_pins();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++)
      v[p] = (m_cfg[p].drive_en && m_cfg[p].clk_mode) ? m_acc[m_cfg[p].gen_sel][31] : pin_data[p];
    return v;
  endfunction

  task automatic write_inc(int g, logic [31:0] v);
    inc_we = 1'b1; inc_idx = 2'(g); inc_val = v;
    cyc();
  endtask

  task automatic write_pin(int p, bit oe, bit ckm, int sel);
    pin_we = 1'b1; pin_idx = 3'(p); pin_oe_set = oe; pin_clk_mode = ckm; pin_gen_sel = 2'(sel);
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 gen_clk", 64'(gen_clk), 64'h0);
    chk("R1 pin_oe", 64'(pin_oe), 64'h0);
    chk("R1 pin_out", 64'(pin_out), 64'(pin_data));
  endtask

  // R5: N = 2^29 gives 4 low / 4 high from zero
  task automatic t_rate();
    write_inc(0, 32'h2000_0000);
    for (int k = 1; k <= 16; k++) begin
      cyc();
      chk("R5 gen0 waveform", 64'(gen_clk[0]), 64'(((k % 8) >= 4) ? 1 : 0));
      chk("R2 others idle", 64'(gen_clk[3:1]), 64'(exp_gen() >> 1));
    end
  endtask

  // R6: retune mid-run, phase carried over
  task automatic t_retune();
    write_inc(1, 32'h1234_5677);
    for (int k = 0; k < 5; k++) begin cyc(); chk("R6 pre-retune", 64'(gen_clk), 64'(exp_gen())); end
    write_inc(1, 32'h6000_0001);
    chk("R6 write edge uses old N", 64'(gen_clk), 64'(exp_gen()));
    for (int k = 0; k < 12; k++) begin cyc(); chk("R6 post-retune", 64'(gen_clk), 64'(exp_gen())); end
  endtask

  // R3: stop holds low
  task automatic t_stop();
    write_inc(1, 32'h0);
    for (int k = 0; k < 8; k++) begin
      cyc();
      chk("R3 stopped low", 64'(gen_clk[1]), 64'h0);
    end
  endtask

  // R4: over-limit write saturates
  task automatic t_saturate();
    write_inc(2, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin cyc(); chk("R4 saturated rate", 64'(gen_clk), 64'(exp_gen())); end
    write_inc(2, 32'h0);
    cyc();
  endtask

  // R7, R8, R9: pin routing
  task automatic t_pins();
    write_inc(1, 32'h4000_0000);
    write_inc(2, 32'h1000_0000);
    write_inc(3, 32'h0);
    pin_data = 8'hA5;
    write_pin(0, 1, 0, 1);   // drive only, data passes
    write_pin(1, 0, 1, 1);   // clock mode but not driven, data passes
    write_pin(2, 1, 1, 0);
    write_pin(3, 1, 1, 1);
    write_pin(4, 1, 1, 2);
    write_pin(5, 1, 1, 3);
    chk("R9 oe bits", 64'(pin_oe), 64'h3D);
    for (int k = 0; k < 16; k++) begin
      cyc();
      chk("R7 R8 pin routing", 64'(pin_out), 64'(exp_pins()));
      chk("R8 pin2 follows gen0", 64'(pin_out[2]), 64'(m_acc[0][31]));
      if (k == 7) pin_data = 8'h5A;
    end
    write_pin(3, 1, 0, 1);
    chk("R7 clock mode cleared", 64'(pin_out[3]), 64'(pin_data[3]));
    write_pin(0, 0, 0, 0);
    chk("R9 oe cleared", 64'(pin_oe), 64'h3C);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int g = 0; g < 4; g++) begin m_inc[g] = '0; m_acc[g] = '0; end
    for (int p = 0; p < NP; p++) m_cfg[p] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_rate();
    t_retune();
    t_stop();
    t_saturate();
    t_pins();
    summary();
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule